// File: doc/BRIEF.md
# Debug Instruction Injection Port

This block is the register front end through which a host places one instruction into a DMA-style instruction engine and starts it. Two APB slave ports reach the same small register set. One port is the secure port and the other is the non-secure port. A configuration input sets the security state of the manager, and that state decides which of the two ports may change the held instruction or start it. Both ports can always read every register.

The host first checks that the busy flag is clear. It then writes the first two instruction bytes and the thread select into one word, and the remaining four bytes into another word. A command word of zero starts the launch. The block then offers the assembled six-byte instruction to the engine over a valid/ready handshake. It holds the offer until the engine takes it, and it stays busy until the engine pulses completion. While the block is busy, the instruction words and the command word are frozen.

Top module: `dbg_inject_port`

## Requirements
- R1: After reset the busy flag is 0, both instruction words read as zero and `inst_valid` is 0.
- R2: Word offsets are 0x0 status (busy in bit 0, other bits zero), 0x4 command (reads zero), 0x8 instruction word A and 0xC instruction word B. Both ports read the same contents. Any other or unaligned address reads zero and ignores writes. Writes to the status word have no effect. `pready` is always 1 and `pslverr` is always 0.
- R3: Instruction word A holds the thread select in bit 0, byte 0 in bits [23:16] and byte 1 in bits [31:24], and reads back in that layout. Byte 0 drives `inst_bytes[7:0]`, byte 1 drives `inst_bytes[15:8]`, and bit 0 drives `inst_thread` (0 selects the manager thread).
- R4: Instruction word B holds bytes 2 to 5 and drives `inst_bytes[47:16]`, with byte 2 in the least significant position. For a channel start, this is the 32-bit address of the first program instruction.
- R5: A permitted write of 0 to the command word while idle sets busy to 1 and raises `inst_valid` on the following cycle.
- R6: A write of any nonzero value to the command word is ignored and leaves busy and `inst_valid` unchanged.
- R7: `inst_valid` stays high with a stable `inst_bytes` and `inst_thread` until the cycle in which `inst_ready` is sampled high, and it drops on the next cycle.
- R8: Busy returns to 0 on the cycle after an `inst_done` pulse that arrives once the engine has accepted the instruction. An `inst_done` pulse that arrives while the request is still pending has no effect.
- R9: While busy is 1, writes to both instruction words and to the command word are ignored.
- R10: With the manager secure (`cfg_mgr_nonsec`=0), writes from the non-secure port to the instruction and command words are ignored.
- R11: With the manager non-secure (`cfg_mgr_nonsec`=1), instruction writes and launches from either port are accepted.
- R12: When both ports write a writable word in the same cycle and both are permitted, only the secure port's write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mgr_nonsec | input | 1 | 1: manager non-secure, 0: manager secure |
| s_psel | input | 1 | Secure port select |
| s_penable | input | 1 | Secure port enable (access phase) |
| s_pwrite | input | 1 | Secure port write strobe |
| s_paddr | input | ADDR_W | Secure port byte address |
| s_pwdata | input | 32 | Secure port write data |
| s_prdata | output | 32 | Secure port read data |
| s_pready | output | 1 | Secure port ready, always 1 |
| s_pslverr | output | 1 | Secure port error, always 0 |
| ns_psel | input | 1 | Non-secure port select |
| ns_penable | input | 1 | Non-secure port enable |
| ns_pwrite | input | 1 | Non-secure port write strobe |
| ns_paddr | input | ADDR_W | Non-secure port byte address |
| ns_pwdata | input | 32 | Non-secure port write data |
| ns_prdata | output | 32 | Non-secure port read data |
| ns_pready | output | 1 | Non-secure port ready, always 1 |
| ns_pslverr | output | 1 | Non-secure port error, always 0 |
| inst_valid | output | 1 | Instruction offered to the engine |
| inst_ready | input | 1 | Engine accepts the offered instruction |
| inst_bytes | output | 48 | Six instruction bytes, byte 0 lowest |
| inst_thread | output | 1 | Thread select, 0 = manager |
| inst_done | input | 1 | Single-cycle completion pulse from the engine |

## Verification
The bench builds the block with the default 12-bit address width. This leaves addresses above the four-word map within reach, so the bench can show that those addresses and unaligned addresses are silently absorbed. The random phase switches the security state between operations and varies the engine's accept and completion delays from zero to several cycles. This reaches back-to-back accept and completion, early completion pulses, and launches and collisions on both ports in both security states.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_BYTES = 6;
  localparam int INST_W    = NUM_BYTES * 8;
  localparam int NUM_PORTS = 2;
  localparam int PORT_SEC  = 0;
  localparam int PORT_NSEC = 1;

  typedef enum logic [2:0] {
    RS_STATUS = 3'd0,
    RS_CMD    = 3'd1,
    RS_INSTA  = 3'd2,
    RS_INSTB  = 3'd3,
    RS_NONE   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic              vld;
    reg_sel_e          sel;
    logic [WORD_W-1:0] data;
  } wr_req_t;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_REQ  = 2'd1,
    LS_WAIT = 2'd2
  } lch_state_e;

  function automatic logic is_writable(input reg_sel_e sel);
    return (sel == RS_CMD) || (sel == RS_INSTA) || (sel == RS_INSTB);
  endfunction
endpackage

// File: rtl/dbg_apb_decode.sv
module dbg_apb_decode
  import dbg_inject_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  output wr_req_t           wr,
  output reg_sel_e          rd_sel
);
  localparam int OFS_W = 4;

  logic     hit;
  reg_sel_e sel;

  always_comb begin
    hit = (paddr[ADDR_W-1:OFS_W] == '0) && (paddr[1:0] == 2'b00);
    sel = RS_NONE;
    if (hit) begin
      unique case (paddr[3:2])
        2'd0: sel = RS_STATUS;
        2'd1: sel = RS_CMD;
        2'd2: sel = RS_INSTA;
        default: sel = RS_INSTB;
      endcase
    end
  end

  always_comb begin
    wr.vld  = psel && penable && pwrite && (sel != RS_NONE);
    wr.sel  = sel;
    wr.data = pwdata;
    rd_sel  = psel ? sel : RS_NONE;
  end
endmodule

// File: rtl/dbg_wr_filter.sv
module dbg_wr_filter
  import dbg_inject_pkg::*;
(
  input  wr_req_t s_wr,
  input  wr_req_t ns_wr,
  input  logic    mgr_nonsec,
  input  logic    busy,
  output wr_req_t win
);
  logic s_ok;
  logic ns_ok;

  always_comb begin
    s_ok  = s_wr.vld && is_writable(s_wr.sel);
    ns_ok = ns_wr.vld && is_writable(ns_wr.sel) && mgr_nonsec;
    win      = '0;
    win.sel  = RS_NONE;
    if (!busy) begin
      if (s_ok) begin
        win = s_wr;
      end else if (ns_ok) begin
        win = ns_wr;
      end
    end
  end
endmodule

// File: rtl/dbg_launch_ctrl.sv
module dbg_launch_ctrl
  import dbg_inject_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic inst_ready,
  input  logic inst_done,
  output logic busy,
  output logic inst_valid
);
  lch_state_e state_q;
  lch_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_IDLE: if (launch)     state_d = LS_REQ;
      LS_REQ:  if (inst_ready) state_d = LS_WAIT;
      LS_WAIT: if (inst_done)  state_d = LS_IDLE;
      default: state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy       = (state_q != LS_IDLE);
  assign inst_valid = (state_q == LS_REQ);
endmodule

// File: rtl/dbg_inject_port.sv
module dbg_inject_port
  import dbg_inject_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mgr_nonsec,
  input  logic              s_psel,
  input  logic              s_penable,
  input  logic              s_pwrite,
  input  logic [ADDR_W-1:0] s_paddr,
  input  logic [31:0]       s_pwdata,
  output logic [31:0]       s_prdata,
  output logic              s_pready,
  output logic              s_pslverr,
  input  logic              ns_psel,
  input  logic              ns_penable,
  input  logic              ns_pwrite,
  input  logic [ADDR_W-1:0] ns_paddr,
  input  logic [31:0]       ns_pwdata,
  output logic [31:0]       ns_prdata,
  output logic              ns_pready,
  output logic              ns_pslverr,
  output logic              inst_valid,
  input  logic              inst_ready,
  output logic [47:0]       inst_bytes,
  output logic              inst_thread,
  input  logic              inst_done
);
  localparam int HIGH_W = INST_W - 16;

  logic              psel_a    [NUM_PORTS];
  logic              penable_a [NUM_PORTS];
  logic              pwrite_a  [NUM_PORTS];
  logic [ADDR_W-1:0] paddr_a   [NUM_PORTS];
  logic [WORD_W-1:0] pwdata_a  [NUM_PORTS];
  logic [WORD_W-1:0] prdata_a  [NUM_PORTS];
  wr_req_t           wr_a      [NUM_PORTS];
  reg_sel_e          rsel_a    [NUM_PORTS];

  wr_req_t win;
  logic    busy;
  logic    launch;
  logic    ld_insta;
  logic    ld_instb;

  logic [7:0]        byte0_q, byte0_d;
  logic [7:0]        byte1_q, byte1_d;
  logic              thr_q, thr_d;
  logic [HIGH_W-1:0] instb_q, instb_d;

  assign psel_a[PORT_SEC]     = s_psel;
  assign penable_a[PORT_SEC]  = s_penable;
  assign pwrite_a[PORT_SEC]   = s_pwrite;
  assign paddr_a[PORT_SEC]    = s_paddr;
  assign pwdata_a[PORT_SEC]   = s_pwdata;
  assign psel_a[PORT_NSEC]    = ns_psel;
  assign penable_a[PORT_NSEC] = ns_penable;
  assign pwrite_a[PORT_NSEC]  = ns_pwrite;
  assign paddr_a[PORT_NSEC]   = ns_paddr;
  assign pwdata_a[PORT_NSEC]  = ns_pwdata;

  function automatic logic [WORD_W-1:0] read_word(
    input reg_sel_e          sel,
    input logic              bsy,
    input logic [7:0]        b0,
    input logic [7:0]        b1,
    input logic              thr,
    input logic [HIGH_W-1:0] hi
  );
    logic [WORD_W-1:0] w;
    w = '0;
    unique case (sel)
      RS_STATUS: w[0] = bsy;
      RS_INSTA:  w = {b1, b0, 15'd0, thr};
      RS_INSTB:  w = hi;
      default:   w = '0;
    endcase
    return w;
  endfunction

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dbg_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .psel    (psel_a[p]),
      .penable (penable_a[p]),
      .pwrite  (pwrite_a[p]),
      .paddr   (paddr_a[p]),
      .pwdata  (pwdata_a[p]),
      .wr      (wr_a[p]),
      .rd_sel  (rsel_a[p])
    );
    assign prdata_a[p] = read_word(rsel_a[p], busy, byte0_q, byte1_q, thr_q, instb_q);
  end

  dbg_wr_filter u_filter (
    .s_wr       (wr_a[PORT_SEC]),
    .ns_wr      (wr_a[PORT_NSEC]),
    .mgr_nonsec (cfg_mgr_nonsec),
    .busy       (busy),
    .win        (win)
  );

  always_comb begin
    ld_insta = win.vld && (win.sel == RS_INSTA);
    ld_instb = win.vld && (win.sel == RS_INSTB);
    launch   = win.vld && (win.sel == RS_CMD) && (win.data == '0);
    byte0_d  = win.data[23:16];
    byte1_d  = win.data[31:24];
    thr_d    = win.data[0];
    instb_d  = win.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte0_q <= '0;
      byte1_q <= '0;
      thr_q   <= 1'b0;
    end else if (ld_insta) begin
      byte0_q <= byte0_d;
      byte1_q <= byte1_d;
      thr_q   <= thr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instb_q <= '0;
    end else if (ld_instb) begin
      instb_q <= instb_d;
    end
  end

  dbg_launch_ctrl u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .inst_ready (inst_ready),
    .inst_done  (inst_done),
    .busy       (busy),
    .inst_valid (inst_valid)
  );

  assign inst_bytes  = {instb_q, byte1_q, byte0_q};
  assign inst_thread = thr_q;

  assign s_prdata   = prdata_a[PORT_SEC];
  assign ns_prdata  = prdata_a[PORT_NSEC];
  assign s_pready   = 1'b1;
  assign ns_pready  = 1'b1;
  assign s_pslverr  = 1'b0;
  assign ns_pslverr = 1'b0;
endmodule

// File: rtl/dbg_inject_chk.sv
module dbg_inject_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        inst_valid,
  input logic        inst_ready,
  input logic        inst_done,
  input logic [47:0] inst_bytes,
  input logic        inst_thread
);
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && !inst_ready |=> inst_valid);

  // R7
  payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && !inst_ready |=> $stable(inst_bytes) && $stable(inst_thread));

  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && inst_ready |=> !inst_valid);

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(inst_bytes) && $stable(inst_thread));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (inst_valid || !inst_done) |=> busy);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !inst_valid && inst_done |=> !busy);

  // R5
  offer_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inst_valid) |-> busy);
endmodule

bind dbg_inject_port dbg_inject_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .inst_valid  (inst_valid),
  .inst_ready  (inst_ready),
  .inst_done   (inst_done),
  .inst_bytes  (inst_bytes),
  .inst_thread (inst_thread)
);

// File: tb/tb_dbg_inject_port.sv
module tb_dbg_inject_port;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int WD_CYCLES  = 100000;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h000;
  localparam logic [ADDR_W-1:0] A_CMD  = 12'h004;
  localparam logic [ADDR_W-1:0] A_INSA = 12'h008;
  localparam logic [ADDR_W-1:0] A_INSB = 12'h00C;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_mgr_nonsec;
  logic s_psel, s_penable, s_pwrite;
  logic [ADDR_W-1:0] s_paddr;
  logic [31:0] s_pwdata, s_prdata;
  logic s_pready, s_pslverr;
  logic ns_psel, ns_penable, ns_pwrite;
  logic [ADDR_W-1:0] ns_paddr;
  logic [31:0] ns_pwdata, ns_prdata;
  logic ns_pready, ns_pslverr;
  logic inst_valid, inst_ready, inst_thread, inst_done;
  logic [47:0] inst_bytes;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0]  m_b0, m_b1;
  logic        m_thr;
  logic [31:0] m_hi;
  logic        m_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_inject_port #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mgr_nonsec(cfg_mgr_nonsec),
    .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
    .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_prdata(s_prdata),
    .s_pready(s_pready), .s_pslverr(s_pslverr),
    .ns_psel(ns_psel), .ns_penable(ns_penable), .ns_pwrite(ns_pwrite),
    .ns_paddr(ns_paddr), .ns_pwdata(ns_pwdata), .ns_prdata(ns_prdata),
    .ns_pready(ns_pready), .ns_pslverr(ns_pslverr),
    .inst_valid(inst_valid), .inst_ready(inst_ready), .inst_bytes(inst_bytes),
    .inst_thread(inst_thread), .inst_done(inst_done)
  );

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_bytes();
    return {m_hi, m_b1, m_b0};
  endfunction

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
    case (a)
      A_STAT:  return {31'd0, m_busy};
      A_INSA:  return {m_b1, m_b0, 15'd0, m_thr};
      A_INSB:  return m_hi;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit writable(input logic [ADDR_W-1:0] a);
    return (a == A_CMD) || (a == A_INSA) || (a == A_INSB);
  endfunction

  function automatic void model_apply(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    if (m_busy) return;
    case (a)
      A_INSA: begin m_b0 = d[23:16]; m_b1 = d[31:24]; m_thr = d[0]; end
      A_INSB: m_hi = d;
      A_CMD:  if (d == 32'd0) m_busy = 1'b1;
      default: ;
    endcase
  endfunction

  function automatic void model_write(input int p, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    if (p == 0 || cfg_mgr_nonsec) model_apply(a, d);
  endfunction

  task automatic drive(input int p, input logic sel, input logic en, input logic wr,
                       input logic [ADDR_W-1:0] a, input logic [31:0] d);
    if (p == 0) begin
      s_psel = sel; s_penable = en; s_pwrite = wr; s_paddr = a; s_pwdata = d;
    end else begin
      ns_psel = sel; ns_penable = en; ns_pwrite = wr; ns_paddr = a; ns_pwdata = d;
    end
  endtask

  task automatic apb_write(input int p, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    drive(p, 1'b1, 1'b0, 1'b1, a, d);
    @(negedge clk);
    drive(p, 1'b1, 1'b1, 1'b1, a, d);
    @(negedge clk);
    drive(p, 1'b0, 1'b0, 1'b0, '0, '0);
    model_write(p, a, d);
  endtask

  task automatic dual_write(input logic [ADDR_W-1:0] a0, input logic [31:0] d0,
                            input logic [ADDR_W-1:0] a1, input logic [31:0] d1);
    drive(0, 1'b1, 1'b0, 1'b1, a0, d0);
    drive(1, 1'b1, 1'b0, 1'b1, a1, d1);
    @(negedge clk);
    drive(0, 1'b1, 1'b1, 1'b1, a0, d0);
    drive(1, 1'b1, 1'b1, 1'b1, a1, d1);
    @(negedge clk);
    drive(0, 1'b0, 1'b0, 1'b0, '0, '0);
    drive(1, 1'b0, 1'b0, 1'b0, '0, '0);
    if (writable(a0)) model_write(0, a0, d0);
    else if (writable(a1)) model_write(1, a1, d1);
  endtask

  task automatic apb_read(input int p, input logic [ADDR_W-1:0] a, output logic [31:0] d);
    drive(p, 1'b1, 1'b0, 1'b0, a, '0);
    @(negedge clk);
    drive(p, 1'b1, 1'b1, 1'b0, a, '0);
    #1;
    if (p == 0) begin
      d = s_prdata;
      chk_eq("R2 s_pready/pslverr", {s_pready, s_pslverr}, 2'b10);
    end else begin
      d = ns_prdata;
      chk_eq("R2 ns_pready/pslverr", {ns_pready, ns_pslverr}, 2'b10);
    end
    @(negedge clk);
    drive(p, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic read_chk(input string tag, input int p, input logic [ADDR_W-1:0] a);
    logic [31:0] d;
    apb_read(p, a, d);
    chk_eq(tag, d, exp_read(a));
  endtask

  task automatic engine_run(input int rdy_dly, input int done_dly);
    for (int i = 0; i < rdy_dly; i++) begin
      chk_eq("R7 valid held", inst_valid, 1'b1);
      chk_eq("R3 R4 offered bytes", {inst_thread, inst_bytes}, {m_thr, exp_bytes()});
      @(negedge clk);
    end
    chk_eq("R7 valid before accept", inst_valid, 1'b1);
    inst_ready = 1'b1;
    @(negedge clk);
    inst_ready = 1'b0;
    chk_eq("R7 valid drops after accept", inst_valid, 1'b0);
    for (int i = 0; i < done_dly; i++) @(negedge clk);
    read_chk("R8 busy until done", 0, A_STAT);
    inst_done = 1'b1;
    @(negedge clk);
    inst_done = 1'b0;
    m_busy = 1'b0;
    read_chk("R8 busy clears after done", 1, A_STAT);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_mgr_nonsec = 1'b0;
    inst_ready = 1'b0; inst_done = 1'b0;
    drive(0, 1'b0, 1'b0, 1'b0, '0, '0);
    drive(1, 1'b0, 1'b0, 1'b0, '0, '0);
    m_b0 = '0; m_b1 = '0; m_thr = 1'b0; m_hi = '0; m_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1 inst_valid after reset", inst_valid, 1'b0);
    read_chk("R1 status after reset", 0, A_STAT);
    read_chk("R1 word A after reset", 1, A_INSA);
    read_chk("R1 word B after reset", 0, A_INSB);

    // R2 R3 R4 layout and readback through the other port
    apb_write(0, A_INSA, 32'h3C5A_0001);
    read_chk("R3 word A readback", 1, A_INSA);
    apb_write(0, A_INSB, 32'h8000_1234);
    read_chk("R4 word B readback", 1, A_INSB);
    read_chk("R2 command reads zero", 0, A_CMD);
    read_chk("R2 unmapped reads zero", 0, 12'h010);
    apb_write(0, 12'h00A, 32'hFFFF_FFFF);
    read_chk("R2 unaligned write ignored", 0, A_INSA);
    apb_write(0, A_STAT, 32'hFFFF_FFFF);
    read_chk("R2 status write ignored", 1, A_STAT);
    chk_eq("R3 R4 static bytes", {inst_thread, inst_bytes}, {1'b1, 48'h8000_1234_3C5A});

    // R6 nonzero command
    apb_write(0, A_CMD, 32'h0000_0005);
    chk_eq("R6 nonzero command no offer", inst_valid, 1'b0);
    read_chk("R6 nonzero command status", 0, A_STAT);

    // R10 secure manager drops non-secure writes and launch
    apb_write(1, A_INSB, 32'h0000_DEAD);
    read_chk("R10 ns word B ignored", 0, A_INSB);
    apb_write(1, A_CMD, 32'd0);
    chk_eq("R10 ns launch ignored", inst_valid, 1'b0);
    read_chk("R10 status after ns launch", 0, A_STAT);

    // R5 launch
    apb_write(0, A_CMD, 32'd0);
    chk_eq("R5 offer next cycle", inst_valid, 1'b1);
    chk_eq("R3 R4 launched bytes", {inst_thread, inst_bytes}, {1'b1, 48'h8000_1234_3C5A});
    read_chk("R5 busy set", 0, A_STAT);

    // R9 writes while busy
    apb_write(0, A_INSB, 32'h1111_1111);
    read_chk("R9 word B frozen", 0, A_INSB);
    apb_write(0, A_INSA, 32'h0000_0000);
    read_chk("R9 word A frozen", 1, A_INSA);

    // R8 early done ignored
    inst_done = 1'b1;
    @(negedge clk);
    inst_done = 1'b0;
    chk_eq("R8 early done keeps offer", inst_valid, 1'b1);
    read_chk("R8 early done keeps busy", 0, A_STAT);
    engine_run(3, 2);

    // R11 non-secure manager accepts non-secure port
    cfg_mgr_nonsec = 1'b1;
    apb_write(1, A_INSA, 32'h7766_0000);
    read_chk("R11 ns word A accepted", 0, A_INSA);
    apb_write(1, A_CMD, 32'd0);
    chk_eq("R11 ns launch offer", inst_valid, 1'b1);
    chk_eq("R3 manager thread select", inst_thread, 1'b0);
    engine_run(0, 0);

    // R12 collision
    dual_write(A_INSB, 32'hAAAA_0001, A_INSB, 32'hBBBB_0002);
    read_chk("R12 secure wins word B", 1, A_INSB);
    dual_write(A_INSA, 32'h1234_0000, A_CMD, 32'd0);
    chk_eq("R12 ns launch lost", inst_valid, 1'b0);
    read_chk("R12 secure word A taken", 0, A_INSA);

    // random phase
    for (int it = 0; it < 150; it++) begin
      int op, p;
      logic [ADDR_W-1:0] a, a2;
      logic [31:0] d;
      cfg_mgr_nonsec = 1'($urandom_range(0, 1));
      p  = int'($urandom_range(0, 1));
      op = int'($urandom_range(0, 4));
      d  = $urandom();
      case (op)
        0: apb_write(p, A_INSA, d);
        1: apb_write(p, A_INSB, d);
        2: apb_write(p, A_CMD, ($urandom_range(0, 1) == 0) ? 32'd0 : (d | 32'd1));
        3: begin
          a = 12'(4 * $urandom_range(0, 4));
          read_chk("R2 random read", p, a);
        end
        default: begin
          a  = 12'(4 * $urandom_range(0, 3));
          a2 = 12'(4 * $urandom_range(0, 3));
          dual_write(a, d, a2, $urandom() & ($urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'd0));
        end
      endcase
      chk_eq("R5 R10 R11 R12 offer matches model", inst_valid, m_busy);
      if (m_busy) begin
        if ($urandom_range(0, 1) == 1) begin
          apb_write(int'($urandom_range(0, 1)), A_INSB, $urandom());
        end
        engine_run(int'($urandom_range(0, 4)), int'($urandom_range(0, 4)));
      end
      read_chk("R9 R11 random word A", 1 - p, A_INSA);
    end

    finished = 1'b1;
    report();
    $finish;
  end
endmodule